// File: doc/BRIEF.md
# Port Retry Queue Manager

This block tracks which requester ports were turned away by an interconnect and still owe a retry. It keeps their identifiers in first-come order and presents the oldest one as the head, which is the next port to be offered a retry. Each port also has a membership flag. The flag makes sure a port can hold at most one place in the queue, so a queue as deep as the number of ports can never overflow.

A refusal is handled according to whether a retry is in progress. A pop grants the retry to the head: it removes that entry and starts a retry-in-progress phase. The phase ends at the next refusal or when the done input is asserted.

Refusals during that phase follow their own rules:
- A refused port that is already queued must be the head. It then keeps its place and no second entry is made.
- Outside a retry phase, refusing a port that is already queued is a protocol error.
- Both kinds of violation raise one-cycle error pulses.

Top module: `retry_queue_mgr`

## Requirements
- R1: After reset the queue is empty (`empty`=1), every membership flag is 0, `retry_active` is 0, and both error outputs are 0.
- R2: A refusal that arrives with no retry in progress, for a port that is not queued, appends the port at the tail. One cycle later its flag in `member` (bit index = port identifier) is 1 and `empty` is 0.
- R3: `head_id` always shows the oldest queued identifier. A pop on a non-empty queue with no refusal in the same cycle does three things: it removes the head, clears that port's flag, and exposes the next-oldest entry one cycle later.
- R4: A refusal with no retry in progress, for a port that is already queued, makes `err_dup` 1 for exactly one cycle. The queue contents and the flags stay unchanged.
- R5: A pop that takes effect sets `retry_active` one cycle later. It stays 1 until a refusal or a done request clears it.
- R6: A refusal during a retry phase for the port currently at the head adds no entry and leaves the head and the flags unchanged. It clears `retry_active`.
- R7: A refusal during a retry phase for a queued port that is not the head makes `err_head` 1 for one cycle. The queue is left unchanged and `retry_active` is cleared.
- R8: A refusal during a retry phase for a port that is not queued appends it at the tail, sets its flag and clears `retry_active`.
- R9: A pop while the queue is empty has no effect on the queue, the flags or `retry_active`.
- R10: When a refusal and a pop arrive in the same cycle, the refusal is processed and the pop is ignored.
- R11: The number of queued entries always equals the number of set membership flags and never exceeds NUM_PORTS. All NUM_PORTS ports can be queued at once.
- R12: `retry_done` clears `retry_active` one cycle later. If a pop takes effect in the same cycle, the pop wins and `retry_active` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| refuse_vld | input | 1 | A transfer from port `refuse_id` was refused this cycle |
| refuse_id | input | ID_W | Identifier of the refused port, below NUM_PORTS |
| pop | input | 1 | Retry granted to the head: remove it and start a retry phase |
| retry_done | input | 1 | Ends the current retry phase |
| head_id | output | ID_W | Oldest queued identifier, meaningful while `empty` is 0 |
| empty | output | 1 | Queue holds no entries |
| member | output | NUM_PORTS | Per-port queued flags |
| retry_active | output | 1 | A retry phase is in progress |
| err_dup | output | 1 | One-cycle pulse: already-queued port refused outside a retry phase |
| err_head | output | 1 | One-cycle pulse: queued port other than the head refused during a retry phase |

## Verification
The bound checker watches the invariants on every cycle:
- the entry count matches the flag count;
- a non-duplicate refusal sets its flag;
- an effective pop clears the old head's flag and opens a retry phase;
- an empty pop changes nothing;
- any refusal ends a retry phase;
- a duplicate refusal leaves the flags untouched;
- the two error pulses never coincide.

First-in, first-out order over long sequences cannot be shown by a one-cycle property. Neither can keeping a port at the head after a failed retry, or the exact pairing of each error with its protocol case. These are shown by the bench's directed scenarios and its long random sweep, compared against a queue model.

// File: rtl/retry_queue_pkg.sv
package retry_queue_pkg;

   typedef enum logic [2:0] {
      RFS_NONE      = 3'd0,
      RFS_APPEND    = 3'd1,
      RFS_KEEP_HEAD = 3'd2,
      RFS_DUP_ERR   = 3'd3,
      RFS_HEAD_ERR  = 3'd4
   } refuse_action_e;

   function automatic int id_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/rq_id_fifo.sv
module rq_id_fifo #(
   parameter int DEPTH = 8,
   parameter int W     = 3,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [W-1:0]     din,
   output logic [W-1:0]     head,
   output logic [CNT_W-1:0] count
);
   logic [W-1:0] slots [DEPTH];
   logic [W-1:0] wr_ptr, rd_ptr;

   function automatic logic [W-1:0] advance(input logic [W-1:0] p);
      return (p == W'(DEPTH - 1)) ? '0 : p + W'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (push) slots[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= advance(wr_ptr);
         if (pop)  rd_ptr <= advance(rd_ptr);
         case ({push, pop})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end

   assign head = slots[rd_ptr];
endmodule

// File: rtl/rq_member_flags.sv
module rq_member_flags #(
   parameter int N = 8,
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_en,
   input  logic [W-1:0] set_id,
   input  logic         clr_en,
   input  logic [W-1:0] clr_id,
   output logic [N-1:0] flags
);
   for (genvar g = 0; g < N; g++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)                             flags[g] <= 1'b0;
         else if (set_en && set_id == W'(g))     flags[g] <= 1'b1;
         else if (clr_en && clr_id == W'(g))     flags[g] <= 1'b0;
      end
   end
endmodule

// File: rtl/rq_ctrl.sv
module rq_ctrl
   import retry_queue_pkg::*;
#(
   parameter int N = 8,
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         refuse_vld,
   input  logic [W-1:0] refuse_id,
   input  logic         pop,
   input  logic         retry_done,
   input  logic         q_empty,
   input  logic [W-1:0] q_head,
   input  logic [N-1:0] flags,
   output logic         do_push,
   output logic         do_pop,
   output logic         retry_active,
   output logic         err_dup,
   output logic         err_head
);
   refuse_action_e act;
   logic           queued;

   assign queued = flags[refuse_id];

   always_comb begin
      act = RFS_NONE;
      if (refuse_vld) begin
         if (!queued)                   act = RFS_APPEND;
         else if (!retry_active)        act = RFS_DUP_ERR;
         else if (refuse_id == q_head)  act = RFS_KEEP_HEAD;
         else                           act = RFS_HEAD_ERR;
      end
   end

   assign do_push = (act == RFS_APPEND);
   assign do_pop  = !refuse_vld && pop && !q_empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         retry_active <= 1'b0;
         err_dup      <= 1'b0;
         err_head     <= 1'b0;
      end else begin
         err_dup  <= (act == RFS_DUP_ERR);
         err_head <= (act == RFS_HEAD_ERR);
         if (refuse_vld)      retry_active <= 1'b0;
         else if (do_pop)     retry_active <= 1'b1;
         else if (retry_done) retry_active <= 1'b0;
      end
   end
endmodule

// File: rtl/retry_queue_mgr.sv
module retry_queue_mgr
   import retry_queue_pkg::*;
#(
   parameter int NUM_PORTS = 8,
   localparam int ID_W  = id_width(NUM_PORTS),
   localparam int CNT_W = $clog2(NUM_PORTS + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 refuse_vld,
   input  logic [ID_W-1:0]      refuse_id,
   input  logic                 pop,
   input  logic                 retry_done,
   output logic [ID_W-1:0]      head_id,
   output logic                 empty,
   output logic [NUM_PORTS-1:0] member,
   output logic                 retry_active,
   output logic                 err_dup,
   output logic                 err_head
);
   if (NUM_PORTS < 2) begin : g_bad_cfg
      $error("retry_queue_mgr: NUM_PORTS must be at least 2");
   end

   logic             push_w, pop_w;
   logic [CNT_W-1:0] occ_w;

   assign empty = (occ_w == '0);

   rq_ctrl #(.N(NUM_PORTS), .W(ID_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .refuse_vld   (refuse_vld),
      .refuse_id    (refuse_id),
      .pop          (pop),
      .retry_done   (retry_done),
      .q_empty      (empty),
      .q_head       (head_id),
      .flags        (member),
      .do_push      (push_w),
      .do_pop       (pop_w),
      .retry_active (retry_active),
      .err_dup      (err_dup),
      .err_head     (err_head)
   );

   rq_id_fifo #(.DEPTH(NUM_PORTS), .W(ID_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_w),
      .pop   (pop_w),
      .din   (refuse_id),
      .head  (head_id),
      .count (occ_w)
   );

   rq_member_flags #(.N(NUM_PORTS), .W(ID_W)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (push_w),
      .set_id (refuse_id),
      .clr_en (pop_w),
      .clr_id (head_id),
      .flags  (member)
   );
endmodule

// File: rtl/retry_queue_mgr_chk.sv
module retry_queue_mgr_chk #(
   parameter int NUM_PORTS = 8,
   parameter int ID_W  = 3,
   parameter int CNT_W = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 refuse_vld,
   input logic [ID_W-1:0]      refuse_id,
   input logic                 pop,
   input logic                 retry_done,
   input logic [ID_W-1:0]      head_id,
   input logic                 empty,
   input logic [NUM_PORTS-1:0] member,
   input logic                 retry_active,
   input logic                 err_dup,
   input logic                 err_head,
   input logic [CNT_W-1:0]     occ
);
   a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(occ) == $countones(member)) && (int'(occ) <= NUM_PORTS));

   a_r2_append_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (refuse_vld && !member[refuse_id]) |=> member[$past(refuse_id)]);

   a_r3_pop_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !refuse_vld && !empty) |=> !member[$past(head_id)]);

   a_r5_pop_starts_retry: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !refuse_vld && !empty) |=> retry_active);

   a_r9_empty_pop_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !refuse_vld && !retry_done) |=> ($stable(member) && $stable(retry_active)));

   a_r6_refuse_ends_retry: assert property (@(posedge clk) disable iff (!rst_n)
      (refuse_vld && retry_active) |=> !retry_active);

   a_r4_dup_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
      err_dup |-> $stable(member));

   a_r7_single_error: assert property (@(posedge clk) disable iff (!rst_n)
      !(err_dup && err_head));
endmodule

bind retry_queue_mgr retry_queue_mgr_chk #(
   .NUM_PORTS(NUM_PORTS), .ID_W(ID_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .refuse_vld(refuse_vld), .refuse_id(refuse_id),
   .pop(pop), .retry_done(retry_done), .head_id(head_id), .empty(empty),
   .member(member), .retry_active(retry_active), .err_dup(err_dup),
   .err_head(err_head), .occ(occ_w)
);

// File: tb/retry_queue_mgr_test.sv
module retry_queue_mgr_test;
   localparam int CLK_PERIOD = 10;
   localparam int NP   = 5;
   localparam int ID_W = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            refuse_vld = 1'b0;
   logic [ID_W-1:0] refuse_id = '0;
   logic            pop = 1'b0;
   logic            retry_done = 1'b0;
   logic [ID_W-1:0] head_id;
   logic            empty;
   logic [NP-1:0]   member;
   logic            retry_active;
   logic            err_dup;
   logic            err_head;

   int n_checks = 0;
   int n_fails  = 0;

   int            mq[$];
   logic [NP-1:0] m_mem = '0;
   bit            m_retry = 0;
   bit            m_dup = 0;
   bit            m_hd = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   retry_queue_mgr #(.NUM_PORTS(NP)) uut (
      .clk(clk), .rst_n(rst_n), .refuse_vld(refuse_vld), .refuse_id(refuse_id),
      .pop(pop), .retry_done(retry_done), .head_id(head_id), .empty(empty),
      .member(member), .retry_active(retry_active), .err_dup(err_dup),
      .err_head(err_head)
   );

   task automatic cmp(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      cmp(tag, "empty", int'(empty), int'(mq.size() == 0));
      cmp(tag, "member", int'(member), int'(m_mem));
      cmp(tag, "retry_active", int'(retry_active), int'(m_retry));
      cmp(tag, "err_dup", int'(err_dup), int'(m_dup));
      cmp(tag, "err_head", int'(err_head), int'(m_hd));
      if (mq.size() != 0) cmp(tag, "head_id", int'(head_id), mq[0]);
   endtask

   // Called at a falling edge; checks after the next rising edge.
   task automatic step(input bit rf, input int id, input bit pp, input bit dn, input string tag);
      refuse_vld = rf; refuse_id = ID_W'(id); pop = pp; retry_done = dn;
      m_dup = 0; m_hd = 0;
      if (rf) begin
         if (!m_mem[id]) begin
            mq.push_back(id); m_mem[id] = 1'b1;
         end else if (!m_retry) begin
            m_dup = 1;
         end else if (mq[0] != id) begin
            m_hd = 1;
         end
         m_retry = 0;
      end else if (pp && mq.size() != 0) begin
         m_mem[mq[0]] = 1'b0;
         void'(mq.pop_front());
         m_retry = 1;
      end else if (dn) begin
         m_retry = 0;
      end
      @(posedge clk); #2;
      check_all(tag);
      @(negedge clk);
      refuse_vld = 1'b0; pop = 1'b0; retry_done = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check_all("R1 reset");
      @(negedge clk);
      rst_n = 1'b1;

      // R2 appends outside a retry phase
      step(1, 2, 0, 0, "R2 first");
      cmp("R2", "head literal", int'(head_id), 2);
      step(1, 4, 0, 0, "R2 second");
      step(1, 0, 0, 0, "R2 third");
      // R4 duplicate outside retry
      step(1, 4, 0, 0, "R4 dup");
      cmp("R4", "err_dup literal", int'(err_dup), 1);
      step(0, 0, 0, 0, "R4 pulse ends");
      // R3 + R5 pop
      step(0, 0, 1, 0, "R3 R5 pop");
      cmp("R3", "head literal", int'(head_id), 4);
      step(0, 0, 0, 0, "R5 holds");
      // R6 head refused again during retry
      step(1, 4, 0, 0, "R6 keep head");
      cmp("R6", "head literal", int'(head_id), 4);
      step(0, 0, 1, 0, "R3 pop again");
      // R8 nonmember during retry
      step(1, 3, 0, 0, "R8 append");
      // R12 done ends retry
      step(0, 0, 1, 0, "R3 pop");
      step(0, 0, 0, 1, "R12 done");
      step(1, 2, 0, 0, "R2 refill");
      step(1, 1, 0, 0, "R2 refill");
      // R7 nonhead member during retry
      step(0, 0, 1, 0, "R3 pop");
      step(1, 1, 0, 0, "R7 not head");
      cmp("R7", "err_head literal", int'(err_head), 1);
      // R10 refusal and pop together
      step(1, 4, 1, 0, "R10 both");
      // R12 pop with done
      step(0, 0, 1, 1, "R12 pop wins");
      // R11 fill every port
      for (int i = 0; i < NP; i++) step(1, i, 0, 0, "R11 fill");
      cmp("R11", "member literal", int'(member), (1 << NP) - 1);
      for (int i = 0; i < NP + 1; i++) step(0, 0, 1, 0, "R3 R9 drain");
      step(0, 0, 1, 0, "R9 empty pop");
      step(0, 0, 1, 0, "R9 empty pop");

      // near-exhaustive random sweep
      for (int k = 0; k < 4000; k++) begin
         int r;
         r = int'($urandom_range(0, 9));
         step(r < 5, int'($urandom_range(0, NP - 1)), (r >= 4 && r < 8),
              (r == 9) || (r == 7), "R3 R6 R7 R8 R11 sweep");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end
endmodule